// File: doc/BRIEF.md
# Auto-Incrementing Coefficient Access Port

This block gives a host a narrow, byte-wide window into three large internal tables: per-pixel offset coefficients, per-pixel gain coefficients and per-colour gamma curves. The host first writes a select register that picks a table and a colour. It then writes a 14-bit start address, split over a high and a low register. The high register also carries a direction bit that fixes whether the following data accesses read or write. After that the host makes any number of data-register accesses, and the block advances the table address by itself.

Gamma entries are one byte each, so the address moves after every byte. Offset and gain entries are 16 bits wide. They travel low byte first, and the address moves after every second byte. For these entries a write reaches memory only when the complete entry has been assembled, and a read fetches the whole entry once. Accesses that fall outside a table, or that use an unused table or colour code, do not touch memory, return zero, and raise a sticky error flag.

The three tables share one request bus that carries a one-hot table select. Memory read data is expected one cycle after the request.

Top module: `coef_port`

## Requirements
- R1: After reset the table and colour codes are 0, the address is 0, the direction is write, the byte phase is first byte, err_o is 0 and no memory request is made.
- R2: Register index 0 holds the table code in bits 3:2 (0 offset, 1 gain, 2 gamma, 3 unused) and the colour code in bits 1:0 (0 red, 1 green, 2 blue, 3 unused). Index 1 holds the direction in bit 6 (1 read, 0 write) and address bits 13:8 in bits 5:0. Index 2 holds address bits 7:0. Index 3 is the data register. Reading index 0 to 2 returns the stored fields, with all other bits 0. Every bus read returns its byte with bus_rvalid_o one cycle after the access.
- R3: With the gamma table selected, each data access in the active direction transfers one byte and adds 1 to the address. The memory address is {colour, 2'b00, address[11:0]} and the write data is {8'h00, byte}.
- R4: With offset or gain selected, a write sends the low byte first. Memory is written only on the second byte, with data {second, first} at memory address {colour, address}. The address advances by 1 after the second byte.
- R5: A coefficient read issues one memory read on the first byte and returns bits 7:0. The second byte returns bits 15:8 and makes no memory request.
- R6: Writing address register 1 or 2 returns the byte phase to the first byte.
- R7: The legal addresses are 0 to 4095 for gamma and 0 to 16383 for offset and gain. Table code 3 and colour code 3 are never legal. An illegal data access makes no memory request and reads back 0, and the address and phase still advance as for a legal access.
- R8: err_o is set by the first illegal data access and stays set until reset.
- R9: A data access whose bus direction differs from the direction bit makes no memory request, leaves the address and phase unchanged, and reads back 0.
- R10: The address wraps from 16383 to 0.
- R11: At most one table request bit (bit 0 offset, bit 1 gain, bit 2 gamma) is high in any cycle, and read data is taken from mem_rdata_i in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Host access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 for a host write, 0 for a host read |
| bus_reg_i | input | 2 | Register index |
| bus_wdata_i | input | 8 | Host write byte |
| bus_rdata_o | output | 8 | Host read byte, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read access |
| mem_req_o | output | 3 | One-hot table request: offset, gain, gamma |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Table address including colour |
| mem_wdata_o | output | 16 | Table write data |
| mem_rdata_i | input | 16 | Table read data, one cycle after request |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
The assertions check on every cycle the rules for address stepping and phase: one step per gamma byte, one step per coefficient pair, a phase cleared by any address write, and no movement on a direction mismatch. They also check that the table select stays one-hot, that err_o stays set, that reads answer in the next cycle, and that illegal or second-byte reads stay off the memory bus. Only the bench's scenarios can show the data itself: that bytes are assembled into the right 16-bit word at the right memory address, that reads return what was written earlier, and that the address wraps at 16383 and runs into the illegal range past 4095 in gamma mode.

// File: rtl/cp_pkg.sv
package cp_pkg;
  typedef enum logic [1:0] {
    TGT_OFFSET = 2'd0,
    TGT_GAIN   = 2'd1,
    TGT_GAMMA  = 2'd2,
    TGT_NONE   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_AHI  = 2'd1,
    REG_ALO  = 2'd2,
    REG_DATA = 2'd3
  } reg_e;

  typedef enum logic [1:0] {
    SRC_BYTE   = 2'd0,
    SRC_MEM_LO = 2'd1,
    SRC_MEM_G  = 2'd2
  } rsrc_e;

  localparam int unsigned COL_W = 2;
  localparam int unsigned N_TBL = 3;
endpackage

// File: rtl/cp_ctrl.sv
module cp_ctrl
  import cp_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_write_i,
  input  logic [1:0]    bus_reg_i,
  input  logic [7:0]    bus_wdata_i,
  output tgt_e          tgt_o,
  output logic [COL_W-1:0] col_o,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          phase_o,
  output logic          acc_o,
  output logic          two_byte_o
);
  tgt_e             tgt_q;
  logic [COL_W-1:0] col_q;
  logic [AW-1:0]    addr_q;
  logic             dir_q, phase_q;
  logic             sel_wr, ahi_wr, alo_wr, data_hit, acc, two_byte;

  assign sel_wr   = bus_valid_i && bus_write_i && (bus_reg_i == REG_SEL);
  assign ahi_wr   = bus_valid_i && bus_write_i && (bus_reg_i == REG_AHI);
  assign alo_wr   = bus_valid_i && bus_write_i && (bus_reg_i == REG_ALO);
  assign data_hit = bus_valid_i && (bus_reg_i == REG_DATA);
  // dir 1 = read: an access counts only when its bus direction matches
  assign acc      = data_hit && (bus_write_i != dir_q);
  assign two_byte = (tgt_q == TGT_OFFSET) || (tgt_q == TGT_GAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= TGT_OFFSET;
      col_q   <= '0;
      addr_q  <= '0;
      dir_q   <= 1'b0;
      phase_q <= 1'b0;
    end else if (sel_wr) begin
      tgt_q <= tgt_e'(bus_wdata_i[3:2]);
      col_q <= bus_wdata_i[1:0];
    end else if (ahi_wr) begin
      dir_q            <= bus_wdata_i[6];
      addr_q[AW-1:8]   <= bus_wdata_i[AW-9:0];
      phase_q          <= 1'b0;
    end else if (alo_wr) begin
      addr_q[7:0] <= bus_wdata_i;
      phase_q     <= 1'b0;
    end else if (acc) begin
      if (two_byte) begin
        phase_q <= !phase_q;
        if (phase_q) addr_q <= addr_q + 1'b1;
      end else begin
        phase_q <= 1'b0;
        addr_q  <= addr_q + 1'b1;
      end
    end
  end

  assign tgt_o      = tgt_q;
  assign col_o      = col_q;
  assign addr_o     = addr_q;
  assign dir_o      = dir_q;
  assign phase_o    = phase_q;
  assign acc_o      = acc;
  assign two_byte_o = two_byte;

  assert_gamma_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && tgt_q == TGT_GAMMA) |=> (addr_q == AW'($past(addr_q) + 1)));

  assert_pair_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && two_byte && phase_q) |=> (!phase_q && addr_q == AW'($past(addr_q) + 1)));

  assert_first_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && two_byte && !phase_q) |=> (phase_q && $stable(addr_q)));

  assert_phase_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ahi_wr || alo_wr) |=> !phase_q);

  assert_mismatch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && !acc) |=> ($stable(addr_q) && $stable(phase_q)));
endmodule

// File: rtl/cp_range.sv
module cp_range
  import cp_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter int unsigned GAMMA_DEPTH = 4096,
  parameter int unsigned COEF_DEPTH  = 16384
) (
  input  tgt_e             tgt_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [AW-1:0]    addr_i,
  output logic             legal_o
);
  localparam logic [AW:0] GAMMA_LIM = (AW+1)'(GAMMA_DEPTH);
  localparam logic [AW:0] COEF_LIM  = (AW+1)'(COEF_DEPTH);

  logic [AW:0] addr_x;
  logic        col_ok;

  assign addr_x = {1'b0, addr_i};
  assign col_ok = (col_i != {COL_W{1'b1}});

  always_comb begin
    unique case (tgt_i)
      TGT_OFFSET, TGT_GAIN: legal_o = col_ok && (addr_x < COEF_LIM);
      TGT_GAMMA:            legal_o = col_ok && (addr_x < GAMMA_LIM);
      default:              legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cp_xfer.sv
module cp_xfer
  import cp_pkg::*;
#(
  parameter int unsigned AW       = 14,
  parameter int unsigned GAMMA_AW = 12,
  localparam int unsigned MEM_AW  = COL_W + AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_reg_i,
  input  logic [7:0]        bus_wdata_i,
  input  tgt_e              tgt_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              dir_i,
  input  logic              phase_i,
  input  logic              acc_i,
  input  logic              two_byte_i,
  input  logic              legal_i,
  output logic [N_TBL-1:0]  mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              err_o
);
  logic [N_TBL-1:0] tbl_sel;
  logic             do_rd, do_wr;
  logic [7:0]       lo_q, hold_q, byte_q, byte_d, ahi_rb;
  rsrc_e            src_q, src_d;
  logic             rvalid_q, err_q;

  for (genvar i = 0; i < N_TBL; i++) begin : g_sel
    assign tbl_sel[i] = (tgt_i == tgt_e'(i));
  end

  assign do_rd = acc_i && legal_i && !bus_write_i && (!two_byte_i || !phase_i);
  assign do_wr = acc_i && legal_i &&  bus_write_i && (!two_byte_i ||  phase_i);

  assign mem_req_o   = (do_rd || do_wr) ? tbl_sel : '0;
  assign mem_we_o    = do_wr;
  assign mem_addr_o  = two_byte_i ? {col_i, addr_i}
                                  : {col_i, {(AW-GAMMA_AW){1'b0}}, addr_i[GAMMA_AW-1:0]};
  assign mem_wdata_o = two_byte_i ? {bus_wdata_i, lo_q} : {8'h00, bus_wdata_i};

  always_comb begin
    ahi_rb            = '0;
    ahi_rb[6]         = dir_i;
    ahi_rb[AW-9:0]    = addr_i[AW-1:8];
  end

  always_comb begin
    src_d  = SRC_BYTE;
    byte_d = '0;
    if (bus_valid_i && !bus_write_i) begin
      unique case (bus_reg_i)
        REG_SEL: byte_d = {4'b0, tgt_i, col_i};
        REG_AHI: byte_d = ahi_rb;
        REG_ALO: byte_d = addr_i[7:0];
        default: begin
          if (acc_i && legal_i) begin
            if (!two_byte_i)   src_d  = SRC_MEM_G;
            else if (!phase_i) src_d  = SRC_MEM_LO;
            else byte_d = (src_q == SRC_MEM_LO) ? mem_rdata_i[15:8] : hold_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hold_q   <= '0;
      byte_q   <= '0;
      src_q    <= SRC_BYTE;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= bus_valid_i && !bus_write_i;
      src_q    <= src_d;
      byte_q   <= byte_d;
      if (src_q == SRC_MEM_LO) hold_q <= mem_rdata_i[15:8];
      if (acc_i && bus_write_i && two_byte_i && !phase_i) lo_q <= bus_wdata_i;
      if (acc_i && !legal_i) err_q <= 1'b1;
    end
  end

  assign bus_rdata_o  = (src_q == SRC_BYTE) ? byte_q : mem_rdata_i[7:0];
  assign bus_rvalid_o = rvalid_q;
  assign err_o        = err_q;

  assert_one_table_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_req_o));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  assert_rd_answer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

  assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !legal_i) |-> (mem_req_o == '0));

  assert_hi_noreq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !bus_write_i && two_byte_i && phase_i) |-> (mem_req_o == '0));
endmodule

// File: rtl/coef_port.sv
module coef_port
  import cp_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter int unsigned GAMMA_DEPTH = 4096,
  parameter int unsigned COEF_DEPTH  = 16384,
  localparam int unsigned GAMMA_AW   = $clog2(GAMMA_DEPTH),
  localparam int unsigned MEM_AW     = COL_W + AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_reg_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [N_TBL-1:0]  mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              err_o
);
  tgt_e             tgt;
  logic [COL_W-1:0] col;
  logic [AW-1:0]    addr;
  logic             dir, phase, acc, two_byte, legal;

  cp_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_reg_i, .bus_wdata_i,
    .tgt_o(tgt), .col_o(col), .addr_o(addr), .dir_o(dir), .phase_o(phase),
    .acc_o(acc), .two_byte_o(two_byte)
  );

  cp_range #(.AW(AW), .GAMMA_DEPTH(GAMMA_DEPTH), .COEF_DEPTH(COEF_DEPTH)) u_range (
    .tgt_i(tgt), .col_i(col), .addr_i(addr), .legal_o(legal)
  );

  cp_xfer #(.AW(AW), .GAMMA_AW(GAMMA_AW)) u_xfer (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_reg_i, .bus_wdata_i,
    .tgt_i(tgt), .col_i(col), .addr_i(addr), .dir_i(dir), .phase_i(phase),
    .acc_i(acc), .two_byte_i(two_byte), .legal_i(legal),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .bus_rdata_o, .bus_rvalid_o, .err_o
  );
endmodule

// File: tb/tb_coef_port.sv
`timescale 1ns/1ps
module tb_coef_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_reg = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [2:0]  mem_req;
  logic        mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        err;

  int checks = 0, fails = 0, req_cnt = 0;
  bit done = 0;
  logic [15:0] mem_m [int];
  logic [15:0] sh [int];

  int m_tgt = 0, m_col = 0, m_addr = 0, m_dir = 0, m_phase = 0;
  logic [7:0] m_lo = '0;

  always #10 clk = ~clk;

  coef_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_reg_i(bus_reg), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .err_o(err)
  );

  // table memory model: index = table*65536 + memory address
  always @(posedge clk) begin
    int k;
    if (mem_req != 3'b000) begin
      k = (mem_req[0] ? 0 : mem_req[1] ? 1 : 2) * 65536 + int'(mem_addr);
      if (mem_we) mem_m[k] = mem_wdata;
      else mem_rdata <= mem_m.exists(k) ? mem_m[k] : 16'h0;
      req_cnt++;
    end
  end

  function automatic bit f_legal(int t, int c, int a);
    if (c == 3) return 0;
    if (t == 2) return a < 4096;
    if (t < 2)  return a < 16384;
    return 0;
  endfunction

  function automatic int f_key(int t, int c, int a);
    if (t == 2) return t * 65536 + c * 16384 + (a % 4096);
    return t * 65536 + c * 16384 + a;
  endfunction

  function automatic logic [15:0] sh_get(int k);
    return sh.exists(k) ? sh[k] : 16'h0;
  endfunction

  function automatic logic [15:0] mem_get(int k);
    return mem_m.exists(k) ? mem_m[k] : 16'h0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [1:0] r, input logic [7:0] d, output logic [7:0] q);
    bus_valid = 1'b1; bus_write = w; bus_reg = r; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    q = bus_rdata;
  endtask

  task automatic t_sel(int t, int c);
    logic [7:0] q;
    op(1'b1, 2'd0, {4'b0, 2'(t), 2'(c)}, q);
    m_tgt = t; m_col = c;
  endtask

  task automatic t_addr(int dir, int a);
    logic [7:0] q;
    op(1'b1, 2'd1, {1'b0, 1'(dir), 6'(a >> 8)}, q);
    op(1'b1, 2'd2, 8'(a), q);
    m_dir = dir; m_addr = a; m_phase = 0;
  endtask

  task automatic t_wr(logic [7:0] b);
    logic [7:0] q;
    bit lg;
    op(1'b1, 2'd3, b, q);
    if (m_dir != 0) return;
    lg = f_legal(m_tgt, m_col, m_addr);
    if (m_tgt >= 2) begin
      if (lg) sh[f_key(m_tgt, m_col, m_addr)] = {8'h00, b};
      m_addr = (m_addr + 1) % 16384; m_phase = 0;
    end else if (m_phase == 0) begin
      m_lo = b; m_phase = 1;
    end else begin
      if (lg) sh[f_key(m_tgt, m_col, m_addr)] = {b, m_lo};
      m_addr = (m_addr + 1) % 16384; m_phase = 0;
    end
  endtask

  task automatic t_rd(string tag);
    logic [7:0] q, e;
    logic [15:0] v;
    bit lg;
    op(1'b0, 2'd3, 8'h00, q);
    lg = f_legal(m_tgt, m_col, m_addr);
    v  = lg ? sh_get(f_key(m_tgt, m_col, m_addr)) : 16'h0;
    if (m_dir != 1) e = 8'h00;
    else if (m_tgt >= 2) begin
      e = v[7:0]; m_addr = (m_addr + 1) % 16384;
    end else if (m_phase == 0) begin
      e = v[7:0]; m_phase = 1;
    end else begin
      e = v[15:8]; m_phase = 0; m_addr = (m_addr + 1) % 16384;
    end
    check(tag, q, e);
  endtask

  task automatic t_rdreg(logic [1:0] r, logic [7:0] exp, string tag);
    logic [7:0] q;
    op(1'b0, r, 8'h00, q);
    check(tag, q, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt0, seed;
    logic [7:0] q;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check("R1 req during reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err_o after reset", int'(err), 0);
    t_rdreg(2'd0, 8'h00, "R1 select reset");
    check("R2 rvalid after read", int'(bus_rvalid), 1);
    t_rdreg(2'd1, 8'h00, "R1 addr hi/dir reset");
    t_rdreg(2'd2, 8'h00, "R1 addr lo reset");
    check("R1 no requests", req_cnt, 0);

    // R2 register readback
    t_sel(2, 2);
    t_rdreg(2'd0, 8'h0A, "R2 select readback");
    t_addr(1, 16'h0F12);
    t_rdreg(2'd1, 8'h4F, "R2 addr hi readback");
    t_rdreg(2'd2, 8'h12, "R2 addr lo readback");

    // R3 gamma writes then reads
    t_sel(2, 1);
    t_addr(0, 100);
    for (int i = 0; i < 5; i++) t_wr(8'hA0 + 8'(i));
    check("R3 gamma mem word", int'(mem_get(2*65536 + 1*16384 + 102)), 16'h00A2);
    t_rdreg(2'd2, 8'd105, "R3 gamma addr step");
    t_addr(1, 100);
    for (int i = 0; i < 5; i++) t_rd("R3 gamma readback");

    // R4 coefficient write with wrap (R10)
    t_sel(0, 0);
    t_addr(0, 16382);
    cnt0 = req_cnt;
    t_wr(8'h34);
    check("R4 no request on first byte", req_cnt, cnt0);
    t_wr(8'h12);
    check("R4 assembled word", int'(mem_get(16382)), 16'h1234);
    t_wr(8'h78); t_wr(8'h56);
    check("R4 second entry", int'(mem_get(16383)), 16'h5678);
    t_rdreg(2'd1, 8'h00, "R10 wrap addr hi");
    t_rdreg(2'd2, 8'h00, "R10 wrap addr lo");

    // R5 coefficient read: one request per entry
    t_addr(1, 16382);
    cnt0 = req_cnt;
    t_rd("R5 low byte");
    check("R5 one request on low byte", req_cnt, cnt0 + 1);
    t_rd("R5 high byte");
    check("R5 no request on high byte", req_cnt, cnt0 + 1);
    t_rd("R5 next low"); t_rd("R5 next high");

    // R6 phase reset by address write
    t_sel(1, 2);
    t_addr(0, 500);
    t_wr(8'hEE);
    t_addr(0, 500);
    t_wr(8'hCD); t_wr(8'hAB);
    check("R6 phase restart", int'(mem_get(65536 + 2*16384 + 500)), 16'hABCD);
    t_rdreg(2'd2, 8'(501), "R6 addr after restart");

    // R7/R8 illegal gamma address
    check("R8 err clear before illegal", int'(err), 0);
    t_sel(2, 0);
    t_addr(0, 4096);
    cnt0 = req_cnt;
    t_wr(8'h55);
    check("R7 no request past gamma limit", req_cnt, cnt0);
    check("R8 err set", int'(err), 1);
    t_rdreg(2'd2, 8'h01, "R7 addr still advances");
    t_addr(1, 4096);
    t_rd("R7 illegal read zero");

    // R7 unused colour and unused table
    t_sel(1, 3);
    t_addr(0, 10);
    cnt0 = req_cnt;
    t_wr(8'h11); t_wr(8'h22);
    check("R7 unused colour no request", req_cnt, cnt0);
    t_sel(3, 0);
    t_wr(8'h33);
    check("R7 unused table no request", req_cnt, cnt0);
    t_addr(1, 10);
    t_rd("R7 unused table read zero");

    // R9 direction mismatch
    t_sel(2, 1);
    t_addr(1, 100);
    cnt0 = req_cnt;
    t_wr(8'h99);
    check("R9 write in read mode no request", req_cnt, cnt0);
    t_rdreg(2'd2, 8'd100, "R9 addr held");
    t_addr(0, 100);
    op(1'b0, 2'd3, 8'h00, q);
    check("R9 read in write mode zero", int'(q), 0);
    check("R9 no request", req_cnt, cnt0);
    t_rdreg(2'd2, 8'd100, "R9 addr held on read");
    t_addr(1, 100);
    t_rd("R9 gamma contents intact");

    // random legal traffic
    for (int it = 0; it < 60; it++) begin
      int t, c, n, a;
      t = int'($urandom_range(0, 2));
      c = int'($urandom_range(0, 2));
      n = int'($urandom_range(1, 4));
      a = (t == 2) ? int'($urandom_range(0, 4095 - n)) : int'($urandom_range(0, 16383));
      t_sel(t, c);
      t_addr(0, a);
      for (int j = 0; j < n * ((t == 2) ? 1 : 2); j++) t_wr(8'($urandom));
      t_addr(1, a);
      for (int j = 0; j < n * ((t == 2) ? 1 : 2); j++)
        t_rd((t == 2) ? "R3 random gamma" : "R4 random coef");
    end
    check("R8 err still set", int'(err), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule